// File: doc/BRIEF.md
# Serial Management Slave Interface

This block is the device-side end of a serial management link. The host drives a free-running clock, an active-low select, a MODE line and a bidirectional DATA line. The block samples all of them on rising edges. A transfer opens when select goes low. Two control bits follow. The first sets the direction and the second sets the address policy. An optional address phase comes next, shifted in MSB first while MODE is high. After it come one or more 8-bit data bytes, also MSB first.

Write bytes land in a small byte-addressed register file. Read bytes are shifted back out on DATA, and the output enable is raised only while the block drives the line. The address register keeps its value between transfers. The host can overwrite only its low bits, or let it count up after each byte. While MODE is held high on the last bit of a byte, a fresh address phase is inserted before the next byte. One register of the file drives an active-low interrupt line.

Top module: `serial_mgmt_slave`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sdata_oe` is 0 and `irq_n` is 1. Every register reads back as 00h.
- R2: Edge 1 of a transfer is the first rising edge with `sel_n` low, and `sdata_i` and `mode_i` are ignored there. Edge 2 samples the direction bit, where 1 means write and 0 means read. Edge 3 samples the address policy bit, where 0 means auto-increment and 1 means fixed address.
- R3: If `mode_i` is 1 at edges 2 and 3, address bits are taken MSB first from edge 4 for as long as `mode_i` stays 1. N received bits (N < 8) replace only the N low bits of the 8-bit address. When more than 8 bits arrive, the last 8 become the address.
- R4: Exactly one clock sits between the control or address phase and the first data bit. On the no-address path that clock is edge 4. On the address path it is the edge that samples `mode_i` low.
- R5: A write byte is sampled MSB first on 8 consecutive edges, and bytes follow back to back while `sel_n` stays low. The byte is stored only at the edge that captures its last bit.
- R6: On a read, the block drives each bit on `sdata_o` after a rising edge so that the host can sample it at the next edge. The first bit appears after the gap clock. `sdata_oe` is 1 only while a read byte is being shifted out and `sel_n` is low.
- R7: In auto-increment mode the address rises by one after every complete byte, read or write, and wraps from FFh to 00h. In fixed mode the address is unchanged.
- R8: `sel_n` sampled high in the middle of a byte ends the transfer at once, and the partial byte is not stored. `sel_n` high on the edge after a last bit ends the transfer normally.
- R9: When `mode_i` is 1 at the edge of a byte's last bit, the next edge is unused and a new address phase (R3) starts on the edge after it. Data then resumes after the gap (R4).
- R10: Only addresses 00h to 0Fh hold registers. Other addresses read as 00h, and writes to them change nothing.
- R11: `irq_n` is 0 while register 0Fh holds a non-zero value, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running management clock, all sampling on rising edges |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Device select, active low; frames a transfer |
| mode_i | input | 1 | High requests or continues an address phase |
| sdata_i | input | 1 | Serial line as seen by the block |
| sdata_o | output | 1 | Serial read data driven by the block |
| sdata_oe | output | 1 | High while the block drives the serial line |
| irq_n | output | 1 | Interrupt, active low, intended for an open-drain pad |

## Verification
The busiest edge is the last bit of a byte. At that one edge the block may store the byte, step the address, fetch the next read byte and accept a request for a new address through MODE. The bench raises MODE on that last bit in both directions. It then reads back the stored byte, the skipped location and the freshly addressed location. Separately, every clock compares the output enable and the interrupt line against a behavioural model of the register file and the address.

// File: rtl/smi_pkg.sv
// Shared types for the serial management slave.
// Assumes: byte-wide data units on the serial link.
package smi_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for select
        S_CTL1,   // next edge samples direction bit
        S_CTL2,   // next edge samples address policy bit
        S_GAP,    // unused clock ahead of data (no address path)
        S_ADDR,   // address bits while MODE is high
        S_DATA,   // byte transfer
        S_AGAP    // unused clock before a re-inserted address phase
    } smi_state_e;
endpackage

// File: rtl/smi_frame_ctrl.sv
// Transfer framing for the serial management slave: tracks the phase of a
// transfer, the direction and address policy bits, and the bit position
// inside a byte, and emits single-cycle strobes for the datapath.
// Assumes: sel_n, mode_i, sdata_i already synchronous to clk.
module smi_frame_ctrl
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic mode_i,
    input  logic sdata_i,
    output logic is_write_o,
    output logic keep_addr_o,
    output logic addr_clear_o,
    output logic addr_shift_o,
    output logic addr_commit_o,
    output logic preload_o,
    output logic data_shift_o,
    output logic byte_done_o,
    output logic read_load_o,
    output logic oe_o
);
    localparam int unsigned BIT_W = $clog2(BYTE_W);

    smi_state_e       state_q;
    logic [BIT_W-1:0] bit_idx_q;
    logic             is_write_q;
    logic             keep_q;
    logic             mode_e2_q;
    logic             active;

    assign active = ~sel_n;

    // Phase sequencing; a high select at any edge returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            bit_idx_q  <= '0;
            is_write_q <= 1'b0;
            keep_q     <= 1'b0;
            mode_e2_q  <= 1'b0;
        end else if (sel_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: state_q <= S_CTL1;
                S_CTL1: begin
                    is_write_q <= sdata_i;
                    mode_e2_q  <= mode_i;
                    state_q    <= S_CTL2;
                end
                S_CTL2: begin
                    keep_q  <= sdata_i;
                    state_q <= (mode_e2_q && mode_i) ? S_ADDR : S_GAP;
                end
                S_GAP: begin
                    bit_idx_q <= BIT_W'(BYTE_W - 1);
                    state_q   <= S_DATA;
                end
                S_ADDR: begin
                    if (!mode_i) begin
                        bit_idx_q <= BIT_W'(BYTE_W - 1);
                        state_q   <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (bit_idx_q == '0) begin
                        bit_idx_q <= BIT_W'(BYTE_W - 1);
                        state_q   <= mode_i ? S_AGAP : S_DATA;
                    end else begin
                        bit_idx_q <= bit_idx_q - 1'b1;
                    end
                end
                S_AGAP:  state_q <= S_ADDR;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Strobes for the address, shift and register-file logic.
    always_comb begin
        addr_clear_o  = active && (state_q == S_CTL2 || state_q == S_AGAP);
        addr_shift_o  = active && state_q == S_ADDR && mode_i;
        addr_commit_o = active && state_q == S_ADDR && !mode_i;
        preload_o     = active && state_q == S_CTL2;
        data_shift_o  = active && state_q == S_DATA;
        byte_done_o   = data_shift_o && bit_idx_q == '0;
        read_load_o   = active && (state_q == S_GAP || addr_commit_o ||
                                   (byte_done_o && !mode_i));
        oe_o          = rst_n && active && state_q == S_DATA && !is_write_q;
    end

    assign is_write_o  = is_write_q;
    assign keep_addr_o = keep_q;

    p_deselect_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && sel_n) |=> state_q == S_IDLE);

    p_bit_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && active && bit_idx_q != '0)
        |=> (state_q == S_DATA && bit_idx_q == $past(bit_idx_q) - 1'b1));

    p_gap_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP && active)
        |=> (state_q == S_DATA && bit_idx_q == BIT_W'(BYTE_W - 1)));

    p_mode_at_last_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_o && mode_i) |=> state_q == S_AGAP);
endmodule

// File: rtl/smi_addr_unit.sv
// Address register of the serial management slave. Collects address bits
// into a side buffer with a saturating count, then merges them LSB-aligned
// into the address. Steps the address after each byte in auto-increment
// mode and applies an optional fixed preload at the policy-bit edge.
// Assumes: strobes from smi_frame_ctrl are mutually exclusive per edge.
module smi_addr_unit #(
    parameter int unsigned ADDR_W      = 8,
    parameter bit          PRELOAD_EN  = 1'b0,
    parameter logic [ADDR_W-1:0] PRELOAD_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              addr_clear,
    input  logic              addr_shift,
    input  logic              addr_commit,
    input  logic              preload,
    input  logic              byte_done,
    input  logic              keep_addr,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] addr_next_o
);
    localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] abuf_q;
    logic [CNT_W-1:0]  acnt_q;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] merged;
    logic              do_preload;

    // One mask bit per address bit: set when that many bits were received.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        assign keep_mask[g] = (acnt_q > CNT_W'(g));
    end

    assign merged = (addr_q & ~keep_mask) | (abuf_q & keep_mask);

    if (PRELOAD_EN) begin : g_preload
        assign do_preload = preload;
    end else begin : g_no_preload
        assign do_preload = 1'b0;
    end

    // Next address: commit, step, preload or hold.
    always_comb begin
        if (addr_commit)                  addr_next_o = merged;
        else if (byte_done && !keep_addr) addr_next_o = addr_q + 1'b1;
        else if (do_preload)              addr_next_o = PRELOAD_VAL;
        else                              addr_next_o = addr_q;
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_next_o;
    end

    // Side buffer and saturating count of received address bits.
    always_ff @(posedge clk) begin
        if (!rst_n || addr_clear) begin
            abuf_q <= '0;
            acnt_q <= '0;
        end else if (addr_shift) begin
            abuf_q <= {abuf_q[ADDR_W-2:0], sdata_i};
            if (acnt_q != CNT_W'(ADDR_W)) acnt_q <= acnt_q + 1'b1;
        end
    end

    assign addr_o = addr_q;

    p_auto_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !keep_addr && !addr_commit)
        |=> addr_q == $past(addr_q) + 1'b1);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(byte_done && !keep_addr) && !addr_commit && !preload)
        |=> $stable(addr_q));

    p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acnt_q <= CNT_W'(ADDR_W));
endmodule

// File: rtl/smi_regfile.sv
// Byte register file behind the serial management slave: implemented
// locations 0..NUM_REGS-1, others read as zero and drop writes. One
// register drives the active-low interrupt.
// Assumes: NUM_REGS <= 2**ADDR_W and IRQ_IDX < NUM_REGS.
module smi_regfile #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned IRQ_IDX  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Storage for one implemented location.
        always_ff @(posedge clk) begin
            if (!rst_n)                            regs_q[g] <= '0;
            else if (we && waddr == ADDR_W'(g))    regs_q[g] <= wdata;
        end
    end

    // Read mux; unimplemented addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == ADDR_W'(i)) rdata = regs_q[i];
        end
    end

    assign irq_n = ~(|regs_q[IRQ_IDX]);

    p_irq_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == ADDR_W'(IRQ_IDX) && wdata != '0) |=> !irq_n);

    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= ADDR_W'(NUM_REGS)) |=> $stable(irq_n));
endmodule

// File: rtl/smi_data_shifter.sv
// Byte shift register shared by both directions: shifts write bits in MSB
// first and presents read bits MSB first, reloading from the register file
// at the gap clock or at a byte's last bit.
// Assumes: read_load and data_shift come from smi_frame_ctrl.
module smi_data_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              data_shift,
    input  logic              read_load,
    input  logic              is_write,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata_o,
    output logic              sdata_o
);
    logic [DATA_W-1:0] sh_q;

    // Load a read byte or shift one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sh_q <= '0;
        else if (read_load && !is_write) sh_q <= rdata;
        else if (data_shift)             sh_q <= {sh_q[DATA_W-2:0], is_write & sdata_i};
    end

    assign wdata_o = {sh_q[DATA_W-2:0], sdata_i};
    assign sdata_o = sh_q[DATA_W-1];

    p_read_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (read_load && !is_write) |=> sdata_o == $past(rdata[DATA_W-1]));
endmodule

// File: rtl/serial_mgmt_slave.sv
// Serial management slave, top level: framing control, address register,
// byte shifter and register file.
// Assumes: host meets the select/MODE protocol; the pad combines sdata_o
// and sdata_oe into the bidirectional line.
module serial_mgmt_slave
    import smi_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned IRQ_IDX     = 15,
    parameter bit          PRELOAD_EN  = 1'b0,
    parameter logic [ADDR_W-1:0] PRELOAD_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic mode_i,
    input  logic sdata_i,
    output logic sdata_o,
    output logic sdata_oe,
    output logic irq_n
);
    localparam int unsigned DATA_W = BYTE_W;

    logic              is_write, keep_addr;
    logic              addr_clear, addr_shift, addr_commit, preload;
    logic              data_shift, byte_done, read_load;
    logic [ADDR_W-1:0] addr_cur, addr_next;
    logic [DATA_W-1:0] rdata, wdata;

    smi_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n        (sel_n),
        .mode_i       (mode_i),
        .sdata_i      (sdata_i),
        .is_write_o   (is_write),
        .keep_addr_o  (keep_addr),
        .addr_clear_o (addr_clear),
        .addr_shift_o (addr_shift),
        .addr_commit_o(addr_commit),
        .preload_o    (preload),
        .data_shift_o (data_shift),
        .byte_done_o  (byte_done),
        .read_load_o  (read_load),
        .oe_o         (sdata_oe)
    );

    smi_addr_unit #(
        .ADDR_W     (ADDR_W),
        .PRELOAD_EN (PRELOAD_EN),
        .PRELOAD_VAL(PRELOAD_VAL)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata_i    (sdata_i),
        .addr_clear (addr_clear),
        .addr_shift (addr_shift),
        .addr_commit(addr_commit),
        .preload    (preload),
        .byte_done  (byte_done),
        .keep_addr  (keep_addr),
        .addr_o     (addr_cur),
        .addr_next_o(addr_next)
    );

    smi_data_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdata_i   (sdata_i),
        .data_shift(data_shift),
        .read_load (read_load),
        .is_write  (is_write),
        .rdata     (rdata),
        .wdata_o   (wdata),
        .sdata_o   (sdata_o)
    );

    smi_regfile #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IRQ_IDX (IRQ_IDX)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (byte_done && is_write),
        .waddr(addr_cur),
        .wdata(wdata),
        .raddr(addr_next),
        .rdata(rdata),
        .irq_n(irq_n)
    );

    p_quiet_when_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!sdata_oe || !sel_n));
endmodule

// File: tb/sim_serial_mgmt_slave.sv
// Bench: host tasks drive the serial protocol at falling edges; a
// behavioural model (register array, address integer) predicts read bytes,
// output enable and interrupt, compared on every clock.
module sim_serial_mgmt_slave;
    logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, mode_i = 1'b0, sdata_i = 1'b0;
    logic sdata_o, sdata_oe, irq_n;

    int   n_run = 0, n_fail = 0;
    int   mem [16];
    int   m_addr = 0;
    bit   m_write = 0, m_keep = 0, exp_oe = 0;

    always #10 clk = ~clk;

    serial_mgmt_slave u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode_i(mode_i),
        .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: sample and compare at the falling edge, then drive.
    task automatic edge_cyc(input logic s, input logic m, input logic d, output logic q);
        @(negedge clk);
        q = sdata_o;
        check(sdata_oe === exp_oe, "R6", "output enable", int'(sdata_oe), int'(exp_oe));
        check(irq_n === (mem[15] == 0), "R11", "interrupt", int'(irq_n), int'(mem[15] == 0));
        sel_n = s; mode_i = m; sdata_i = d;
    endtask

    // Edges 1..3; edge 1 carries junk to show it is ignored (R2).
    task automatic start(input bit w, input bit keep, input bit with_addr);
        logic q;
        edge_cyc(1'b0, 1'b1, ~w, q);
        edge_cyc(1'b0, with_addr, w, q);
        edge_cyc(1'b0, with_addr, keep, q);
        m_write = w; m_keep = keep;
    endtask

    task automatic gap();
        logic q;
        edge_cyc(1'b0, 1'b0, 1'b1, q);
        exp_oe = !m_write;
    endtask

    // n address bits MSB first, then the gap edge; model merges LSB-aligned (R3).
    task automatic addr_phase(input int n, input logic [15:0] v);
        logic q;
        for (int i = n - 1; i >= 0; i--) edge_cyc(1'b0, 1'b1, v[i], q);
        gap();
        if (n >= 8) m_addr = int'(v[7:0]);
        else m_addr = (m_addr & ~((1 << n) - 1)) | (int'(v) & ((1 << n) - 1));
    endtask

    // One full byte; m_last is MODE at the last bit (R9).
    task automatic xbyte(input logic [7:0] wd, input bit m_last, input string req);
        logic q;
        logic [7:0] got;
        for (int b = 7; b >= 0; b--) begin
            edge_cyc(1'b0, (b == 0) ? m_last : 1'b0, wd[b], q);
            got[b] = q;
        end
        if (m_write) begin
            if (m_addr < 16) mem[m_addr] = int'(wd);
        end else begin
            check(got === 8'((m_addr < 16) ? mem[m_addr] : 0), req, "read byte",
                  int'(got), (m_addr < 16) ? mem[m_addr] : 0);
        end
        if (!m_keep) m_addr = (m_addr + 1) & 8'hFF;
        if (m_last) exp_oe = 0;
    endtask

    task automatic reinsert(input int n, input logic [15:0] v);
        logic q;
        edge_cyc(1'b0, 1'b1, 1'b0, q);
        addr_phase(n, v);
    endtask

    task automatic partial(input logic [7:0] wd, input int k);
        logic q;
        for (int b = 7; b > 7 - k; b--) edge_cyc(1'b0, 1'b0, wd[b], q);
    endtask

    task automatic stop();
        logic q;
        edge_cyc(1'b1, 1'b0, 1'b0, q);
        exp_oe = 0;
        edge_cyc(1'b1, 1'b0, 1'b0, q);
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 0;
        repeat (3) @(negedge clk);
        check(sdata_oe === 1'b0, "R1", "oe in reset", int'(sdata_oe), 0);
        check(irq_n === 1'b1, "R1", "irq in reset", int'(irq_n), 1);
        rst_n = 1'b1;

        // R1: reset contents read as zero
        start(0, 0, 1); addr_phase(8, 16'h00); xbyte(8'h00, 0, "R1"); xbyte(8'h00, 0, "R1"); stop();

        // R5: write three bytes back to back with auto-increment
        start(1, 0, 1); addr_phase(8, 16'h02);
        xbyte(8'hA5, 0, "R5"); xbyte(8'h3C, 0, "R5"); xbyte(8'h0F, 0, "R5"); stop();
        // R2 / R7: read them back with auto-increment
        start(0, 0, 1); addr_phase(8, 16'h02);
        xbyte(0, 0, "R2"); xbyte(0, 0, "R7"); xbyte(0, 0, "R7"); stop();

        // R7: fixed address; R4: no-address path keeps it
        start(1, 1, 1); addr_phase(8, 16'h06); xbyte(8'h11, 0, "R7"); xbyte(8'h22, 0, "R7"); stop();
        start(0, 1, 0); gap(); xbyte(0, 0, "R4"); xbyte(0, 0, "R4"); stop();

        // R3: two-bit partial address, then an over-long address
        start(1, 0, 1); addr_phase(2, 16'h1); xbyte(8'h77, 0, "R3"); stop();
        start(1, 0, 1); addr_phase(10, 16'h308); xbyte(8'h99, 0, "R3"); stop();
        start(0, 0, 1); addr_phase(8, 16'h05); xbyte(0, 0, "R3"); stop();
        start(0, 0, 1); addr_phase(8, 16'h08); xbyte(0, 0, "R3"); stop();

        // R9: address re-inserted after a write byte and after a read byte
        start(1, 0, 1); addr_phase(8, 16'h0A); xbyte(8'h44, 1, "R9");
        reinsert(4, 16'hC); xbyte(8'h55, 0, "R9"); stop();
        start(0, 0, 1); addr_phase(8, 16'h0A); xbyte(0, 0, "R9"); xbyte(0, 0, "R9"); xbyte(0, 0, "R9"); stop();
        start(0, 0, 1); addr_phase(8, 16'h02); xbyte(0, 1, "R9");
        reinsert(8, 16'h0C); xbyte(0, 0, "R9"); stop();

        // R8: second byte cut after three bits is not stored
        start(1, 0, 1); addr_phase(8, 16'h0E); xbyte(8'h66, 0, "R8"); partial(8'hFF, 3); stop();
        start(0, 0, 1); addr_phase(8, 16'h0E); xbyte(0, 0, "R8"); xbyte(0, 0, "R8"); stop();

        // R10 / R7: wrap from FFh, unmapped write dropped, unmapped read zero
        start(1, 0, 1); addr_phase(8, 16'hFF); xbyte(8'hEE, 0, "R10"); xbyte(8'hDD, 0, "R7"); stop();
        start(0, 0, 1); addr_phase(8, 16'hFF); xbyte(0, 0, "R10"); xbyte(0, 0, "R7"); stop();
        start(0, 1, 1); addr_phase(8, 16'h80); xbyte(0, 0, "R10"); stop();

        // R11: interrupt register set then cleared
        start(1, 1, 1); addr_phase(8, 16'h0F); xbyte(8'h01, 0, "R11"); stop();
        start(1, 1, 1); addr_phase(8, 16'h0F); xbyte(8'h00, 0, "R11"); stop();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule